// File: doc/BRIEF.md
# IO Reset Control Register

A single byte-wide control register at IO port 0xCF9 on a simple IO bus that has an address, write data, read data, a write strobe and a read strobe. Software uses it in two ways. It can select the reset type and read that choice back. It can also ask for a system reset by writing a value with the trigger bit set. When it does, the block raises a registered request pulse for exactly one clock. The sequencer that acts on the request sits outside this block.

A write that triggers a reset leaves the stored value unchanged. Any other write keeps only the reset-type bit and clears every other bit. The block decodes the full address. An access to any other port has no effect. A read of another port leaves the read data at zero and holds the hit output low, so other responders can drive the bus.

Top module: `io_reset_ctl`

## Requirements
- R1: After reset the stored value is 0x00 and `rst_req` is low.
- R2: Only the exact address 0xCF9, compared on all 16 address bits, is decoded. A write to any other address leaves the stored value unchanged and does not raise `rst_req`.
- R3: A write to 0xCF9 with data bit 2 set makes `rst_req` high for exactly the next clock cycle.
- R4: A write to 0xCF9 with data bit 2 set leaves the stored value unchanged.
- R5: A write to 0xCF9 with data bit 2 clear stores data bit 1 in bit 1 and clears all other stored bits, so the stored value becomes `wdata & 0x02`.
- R6: While `io_rd` is high with address 0xCF9, `io_hit` is high and `io_rdata` carries the stored value in the same cycle.
- R7: A read of any other address keeps `io_hit` low and `io_rdata` at 0x00.
- R8: `rst_req` is high only in the cycle that follows a triggering write to 0xCF9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | IO port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle it is high |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, zero when the register is not addressed |
| io_hit | output | 1 | High when a read addresses this register |
| rst_req | output | 1 | Registered system-reset request pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the port at 0xCF9, the trigger in bit 2 and the type in bit 1. With an 8-bit data path, every one of the 256 write values can be applied to the register. Each write is followed by a read-back and a check on the pulse. This covers both the trigger path and the masking path, including the values that set bit 1 and bit 2 together. Neighbouring ports and an address that differs only in its upper bits are also written with all-ones data and read. This shows that a partial address decode would be caught.

// File: rtl/io_reset_ctl.sv
module io_reset_ctl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int TRIG_BIT = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_hit,
  output logic              rst_req
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;

  logic [DATA_W-1:0] ctl_q;
  logic sel, wr_sel, fire;

  assign sel    = (io_addr == PORT_ADDR);
  assign wr_sel = io_wr & sel;
  assign fire   = wr_sel & io_wdata[TRIG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= fire;
      if (wr_sel && !io_wdata[TRIG_BIT])
        ctl_q <= io_wdata & KEEP_MASK;
    end
  end

  assign io_hit   = io_rd & sel;
  assign io_rdata = io_hit ? ctl_q : '0;

  // R3
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_ADDR && io_wdata[TRIG_BIT]) |=> rst_req);

  // R4
  trig_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_ADDR && io_wdata[TRIG_BIT]) |=> $stable(ctl_q));

  // R5
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_ADDR && !io_wdata[TRIG_BIT])
      |=> (ctl_q == ($past(io_wdata) & KEEP_MASK)));

  // R2
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != PORT_ADDR) |=> ($stable(ctl_q) && !rst_req));

  // R8
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(io_wr && io_addr == PORT_ADDR && io_wdata[TRIG_BIT]));

  // R7
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr != PORT_ADDR) |-> (!io_hit && io_rdata == '0));
endmodule

// File: tb/io_reset_ctl_test.sv
module io_reset_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic hit, req;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] model = 8'h00;

  always #5 clk = ~clk;

  io_reset_ctl uut (
    .clk(clk), .rst_n(rst_n), .io_addr(addr), .io_wdata(wdata),
    .io_wr(wr), .io_rd(rd), .io_rdata(rdata), .io_hit(hit), .rst_req(req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic exp_req);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    check(exp_req ? "R3 pulse" : "R2/R8 no pulse", {7'b0, req}, {7'b0, exp_req});
    @(negedge clk);
    check("R3/R8 pulse width", {7'b0, req}, 8'h00);
  endtask

  task automatic do_read(input logic [15:0] a, input logic exp_hit, input logic [7:0] exp_data,
                         input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    check({tag, " hit"}, {7'b0, hit}, {7'b0, exp_hit});
    check({tag, " data"}, rdata, exp_data);
    rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] others [5];
    others = '{16'h0CF8, 16'h0CFA, 16'h8CF9, 16'h0000, 16'h0DF9};
    repeat (3) @(negedge clk);
    // R1
    check("R1 req after reset", {7'b0, req}, 8'h00);
    do_read(16'h0CF9, 1'b1, 8'h00, "R1 stored after reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 req idle", {7'b0, req}, 8'h00);

    // R3 R4 R5 R6: sweep every data value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = v[7:0];
      do_write(16'h0CF9, d, d[2]);
      if (!d[2]) model = d & 8'h02;
      do_read(16'h0CF9, 1'b1, model, d[2] ? "R4 kept" : "R5/R6 stored");
    end

    // R5: set type bit so the other-address checks see a nonzero value
    do_write(16'h0CF9, 8'hFA, 1'b0);
    model = 8'h02;
    do_read(16'h0CF9, 1'b1, model, "R5 type set");

    // R2 R7: other addresses, trigger-looking data
    foreach (others[i]) begin
      do_write(others[i], 8'hFF, 1'b0);
      do_write(others[i], 8'h00, 1'b0);
      do_read(16'h0CF9, 1'b1, model, "R2 unchanged");
      do_read(others[i], 1'b0, 8'h00, "R7 other read");
    end

    // R6: read strobe low gives no hit
    @(negedge clk);
    addr = 16'h0CF9; rd = 1'b0;
    #1;
    check("R6 no strobe hit", {7'b0, hit}, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule